// File: doc/BRIEF.md
# Banked GPIO Pin Register Block

This block gives software word-wide control over a set of general-purpose pins arranged in groups of 32. Every group has its own window of ten 32-bit registers on a simple register bus. Each window holds the pin directions, an output latch, a readback of the synchronized pad levels, rising-edge and falling-edge enable words, and a pass-through of the interrupt status word. An edge-detection neighbour produces that status word and clears it on request. The output latch can be loaded as a whole word. It can also be changed bit by bit through separate set and clear strobe offsets, so a driver never has to read, modify and write back to change one pin.

The block drives an output-enable and an output value for every pad, and it samples every pad input through a two-flop synchronizer. The synchronized levels and the edge-enable words go straight to the edge-detection block as ports. When software writes the status offset, the write data leaves the block as a one-cycle clear mask for that block. Read data is registered: the word for the address presented in one cycle appears on the read port after the next clock edge.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst_n` is low and after it rises, with no writes since, every direction bit is 1, so every bit of `pad_oe` is 0. Every output latch, every rising-edge enable and every falling-edge enable is 0, and `status_clear` is 0.
- R2: Group g (0 to NUM_GROUPS-1) has word k (0 to 9) at byte address 0x10 + 0x28*g + 4*k. The words in order of k are: direction (0), output latch (1), set strobe (2), clear strobe (3), pad readback (4), rising-enable set (5), rising-enable clear (6), falling-enable set (7), falling-enable clear (8), and status (9).
- R3: A write to the direction word replaces all 32 direction bits, and a read returns them. A direction bit of 1 makes its pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1).
- R4: A write to the set strobe word sets to 1 every output latch bit whose write-data bit is 1. All other latch bits keep their value, so writing zero changes nothing.
- R5: A write to the clear strobe word sets to 0 every output latch bit whose write-data bit is 1. All other latch bits keep their value, so writing zero changes nothing.
- R6: A write to the output latch word replaces the whole latch. `pad_out` shows the latch from the clock edge of the write. Reads of words 1, 2 and 3 all return the latch.
- R7: The pad readback word returns the pad levels through a two-flop synchronizer, whatever the pin directions. A pad change applied just after a clock edge is first seen on a read sampled after the third following edge. `pin_sync` carries the same synchronized levels. Writes to the readback word are ignored.
- R8: Words 5 and 7 set, and words 6 and 8 clear, the bits of the rising-edge and falling-edge enable words where the write data is 1. Reads of words 5 and 6 return the rising enables. Reads of words 7 and 8 return the falling enables. Both words appear on `rise_en` and `fall_en`.
- R9: A read of the status word returns that group's slice of `edge_status`. A write to it drives the write data onto that group's slice of `status_clear` for exactly the one cycle after the write edge. The slices of all other groups stay 0.
- R10: Unmapped addresses read as zero, and writes to them change no register and pulse no `status_clear` bit. Unmapped addresses are those below 0x10, those at or beyond the end of the last group, and those with address bits [1:0] not equal to 0.
- R11: `bus_rdata` is registered. After the address changes, it keeps the previous word until the next clock edge, and it then shows the word for the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also clocks the input synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | NUM_GROUPS*32 (160) | Pad input levels, asynchronous |
| pad_oe | output | NUM_GROUPS*32 (160) | Pad driver enable, 1 = drive |
| pad_out | output | NUM_GROUPS*32 (160) | Pad output values from the output latches |
| pin_sync | output | NUM_GROUPS*32 (160) | Synchronized pad levels for the edge-detection block |
| rise_en | output | NUM_GROUPS*32 (160) | Rising-edge enable words |
| fall_en | output | NUM_GROUPS*32 (160) | Falling-edge enable words |
| edge_status | input | NUM_GROUPS*32 (160) | Pending-edge status from the edge-detection block |
| status_clear | output | NUM_GROUPS*32 (160) | One-cycle clear mask to the edge-detection block |

## Verification
The synchronizer lag is the hardest behaviour to reach from the ports, because a normal read sequence always gives the pad time to settle. The bench changes one group's pads on the same falling edge that puts that group's readback address on the bus. It then samples the registered read data after each of the next three rising edges, and only the third may show the new level. The one-cycle status clear pulse needs the same care. It is sampled on the falling edge just after the write edge and again one cycle later, while every other group's slice is checked to stay zero. Sweeps of all 256 addresses, read before and after loading patterns, and writes to every unmapped address cover the decoder boundaries and the unaligned holes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int REGS_PER_GROUP = 10;
    localparam int REG_IDX_W      = $clog2(REGS_PER_GROUP);

    // word index inside one group window; the order is the address map
    typedef enum logic [REG_IDX_W-1:0] {
        RG_DIR  = 4'd0,
        RG_OUT  = 4'd1,
        RG_SET  = 4'd2,
        RG_CLR  = 4'd3,
        RG_IN   = 4'd4,
        RG_RSET = 4'd5,
        RG_RCLR = 4'd6,
        RG_FSET = 4'd7,
        RG_FCLR = 4'd8,
        RG_STAT = 4'd9
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_GROUPS   = 5,
    parameter int GROUP_BASE   = 16,
    parameter int GROUP_STRIDE = 40
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_GROUPS-1:0] group_hit,
    output reg_sel_e              reg_sel
);

    localparam int EW = ADDR_W + 1;
    localparam logic [EW-1:0] SPAN = EW'(REGS_PER_GROUP * 4);

    logic [EW-1:0]        ext_addr;
    logic [REG_IDX_W-1:0] idx_g [NUM_GROUPS];
    logic [REG_IDX_W-1:0] idx_any;

    assign ext_addr = {1'b0, addr};

    // one window comparator per group; windows must not overlap (stride >= span)
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_win
        localparam logic [EW-1:0] LO = EW'(GROUP_BASE + g * GROUP_STRIDE);
        logic [EW-1:0] diff;
        assign diff         = ext_addr - LO;
        assign group_hit[g] = (ext_addr >= LO) && (diff < SPAN) && (addr[1:0] == 2'b00);
        assign idx_g[g]     = group_hit[g] ? diff[2 +: REG_IDX_W] : '0;
    end

    always_comb begin
        idx_any = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            idx_any = idx_any | idx_g[g];
        end
        reg_sel = reg_sel_e'(idx_any);
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 160,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

    if (STAGES == 2) begin : g_chk
        logic [1:0] settle_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 settle_q <= '0;
            else if (settle_q != 2'd2)  settle_q <= settle_q + 2'd1;
        end
        // R7: readback lags the pad by exactly two clocks
        p_sync_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (settle_q == 2'd2) |-> (q == $past(d, 2)));
    end

endmodule

// File: rtl/gpio_group.sv
module gpio_group
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         we,
    input  reg_sel_e     reg_sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] edge_status,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q,
    output logic [W-1:0] rd_word,
    output logic [W-1:0] status_clear
);

    logic wr;
    assign wr = sel && we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr) begin
            case (reg_sel)
                RG_DIR:  dir_q  <= wdata;
                RG_OUT:  out_q  <= wdata;
                RG_SET:  out_q  <= out_q | wdata;
                RG_CLR:  out_q  <= out_q & ~wdata;
                RG_RSET: rise_q <= rise_q | wdata;
                RG_RCLR: rise_q <= rise_q & ~wdata;
                RG_FSET: fall_q <= fall_q | wdata;
                RG_FCLR: fall_q <= fall_q & ~wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         status_clear <= '0;
        else if (wr && reg_sel == RG_STAT)  status_clear <= wdata;
        else                                status_clear <= '0;
    end

    always_comb begin
        rd_word = '0;
        if (sel) begin
            unique case (reg_sel)
                RG_DIR:                 rd_word = dir_q;
                RG_OUT, RG_SET, RG_CLR: rd_word = out_q;
                RG_IN:                  rd_word = pin_sync;
                RG_RSET, RG_RCLR:       rd_word = rise_q;
                RG_FSET, RG_FCLR:       rd_word = fall_q;
                RG_STAT:                rd_word = edge_status;
                default:                rd_word = '0;
            endcase
        end
    end

    p_dir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_sel == RG_DIR) |=> (dir_q == $past(wdata)));

    p_set_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_sel == RG_SET) |=> (out_q == ($past(out_q) | $past(wdata))));

    p_clr_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_sel == RG_CLR) |=> (out_q == ($past(out_q) & ~$past(wdata))));

    p_rise_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_sel == RG_RSET) |=> (rise_q == ($past(rise_q) | $past(wdata))));

    p_fall_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_sel == RG_FCLR) |=> (fall_q == ($past(fall_q) & ~$past(wdata))));

    p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && reg_sel == RG_STAT) |=> (status_clear == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(dir_q) && $stable(out_q) && $stable(rise_q) && $stable(fall_q)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_GROUPS   = 5,
    parameter int GROUP_BASE   = 16,
    parameter int GROUP_STRIDE = 40,
    parameter int SYNC_STAGES  = 2,
    localparam int W           = 32,
    localparam int NPINS       = NUM_GROUPS * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pin_sync,
    output logic [NPINS-1:0]  rise_en,
    output logic [NPINS-1:0]  fall_en,
    input  logic [NPINS-1:0]  edge_status,
    output logic [NPINS-1:0]  status_clear
);

    logic [NUM_GROUPS-1:0] group_hit;
    reg_sel_e              reg_sel;
    logic [W-1:0]          grp_rd [NUM_GROUPS];
    logic [W-1:0]          rd_next;

    gpio_addr_decode #(
        .ADDR_W       (ADDR_W),
        .NUM_GROUPS   (NUM_GROUPS),
        .GROUP_BASE   (GROUP_BASE),
        .GROUP_STRIDE (GROUP_STRIDE)
    ) u_dec (
        .addr      (bus_addr),
        .group_hit (group_hit),
        .reg_sel   (reg_sel)
    );

    gpio_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [W-1:0] dir_w;
        logic [W-1:0] out_w;
        logic [W-1:0] rise_w;
        logic [W-1:0] fall_w;
        logic [W-1:0] clr_w;

        gpio_group #(.W(W)) u_group (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (group_hit[g]),
            .we           (bus_we),
            .reg_sel      (reg_sel),
            .wdata        (bus_wdata),
            .pin_sync     (pin_sync[g*W +: W]),
            .edge_status  (edge_status[g*W +: W]),
            .dir_q        (dir_w),
            .out_q        (out_w),
            .rise_q       (rise_w),
            .fall_q       (fall_w),
            .rd_word      (grp_rd[g]),
            .status_clear (clr_w)
        );

        // direction 1 = input, so the driver enable is the complement
        assign pad_oe[g*W +: W]       = ~dir_w;
        assign pad_out[g*W +: W]      = out_w;
        assign rise_en[g*W +: W]      = rise_w;
        assign fall_en[g*W +: W]      = fall_w;
        assign status_clear[g*W +: W] = clr_w;
    end

    always_comb begin
        rd_next = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            rd_next = rd_next | grp_rd[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    p_window_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(group_hit));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(group_hit == '0) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;

    localparam int NG = 5;
    localparam int W  = 32;
    localparam int N  = NG * W;
    localparam int BASE = 16;
    localparam int STRIDE = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pin_sync;
    logic [N-1:0]  rise_en;
    logic [N-1:0]  fall_en;
    logic [N-1:0]  edge_status = '0;
    logic [N-1:0]  status_clear;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [W-1:0] m_dir  [NG];
    logic [W-1:0] m_out  [NG];
    logic [W-1:0] m_rise [NG];
    logic [W-1:0] m_fall [NG];
    logic [W-1:0] m_pad  [NG];
    logic [W-1:0] m_stat [NG];

    gpio_bank_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pin_sync     (pin_sync),
        .rise_en      (rise_en),
        .fall_en      (fall_en),
        .edge_status  (edge_status),
        .status_clear (status_clear)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog all-reqs actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int reg_addr(input int g, input int k);
        return BASE + STRIDE * g + 4 * k;
    endfunction

    function automatic bit is_mapped(input int a);
        return (a % 4 == 0) && (a >= BASE) && (a < BASE + NG * STRIDE);
    endfunction

    function automatic logic [W-1:0] exp_read(input int a);
        int g;
        int k;
        if (!is_mapped(a)) return '0;
        g = (a - BASE) / STRIDE;
        k = ((a - BASE) % STRIDE) / 4;
        case (k)
            0:       return m_dir[g];
            1, 2, 3: return m_out[g];
            4:       return m_pad[g];
            5, 6:    return m_rise[g];
            7, 8:    return m_fall[g];
            9:       return m_stat[g];
            default: return '0;
        endcase
    endfunction

    task automatic bus_write(input int a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr  = 8'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = 8'(a);
        bus_we   = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic set_pad(input int g, input logic [W-1:0] v);
        m_pad[g] = v;
        pad_in[g*W +: W] = v;
    endtask

    task automatic set_stat(input int g, input logic [W-1:0] v);
        m_stat[g] = v;
        edge_status[g*W +: W] = v;
    endtask

    task automatic check_ports();
        for (int g = 0; g < NG; g++) begin
            chk("R3 pad_oe", pad_oe[g*W +: W], ~m_dir[g]);
            chk("R6 pad_out", pad_out[g*W +: W], m_out[g]);
            chk("R8 rise_en", rise_en[g*W +: W], m_rise[g]);
            chk("R8 fall_en", fall_en[g*W +: W], m_fall[g]);
            chk("R7 pin_sync", pin_sync[g*W +: W], m_pad[g]);
        end
    endtask

    task automatic read_sweep();
        logic [W-1:0] v;
        for (int a = 0; a < 256; a++) begin
            bus_read(a, v);
            chk(is_mapped(a) ? "R2 map read" : "R10 unmapped read", v, exp_read(a));
        end
    endtask

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] vprev;
        logic [W-1:0] pat;

        for (int g = 0; g < NG; g++) begin
            m_dir[g] = '1; m_out[g] = '0; m_rise[g] = '0; m_fall[g] = '0;
            set_pad(g, 32'hA5C3_0F69 ^ (32'h1111_1111 * g));
            set_stat(g, 32'h0BAD_F00D + 32'(g * 7));
        end
        repeat (3) @(negedge clk);

        // R1: during reset
        for (int g = 0; g < NG; g++) begin
            chk("R1 oe in reset", pad_oe[g*W +: W], '0);
            chk("R1 out in reset", pad_out[g*W +: W], '0);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: after reset
        for (int g = 0; g < NG; g++) begin
            chk("R1 oe", pad_oe[g*W +: W], '0);
            chk("R1 out", pad_out[g*W +: W], '0);
            chk("R1 rise", rise_en[g*W +: W], '0);
            chk("R1 fall", fall_en[g*W +: W], '0);
            chk("R1 clear", status_clear[g*W +: W], '0);
            bus_read(reg_addr(g, 0), v);
            chk("R1 dir read", v, '1);
        end

        read_sweep();

        for (int g = 0; g < NG; g++) begin
            pat = 32'h0F0F_3C3C ^ (32'h1111_1111 * g);
            bus_write(reg_addr(g, 0), pat); m_dir[g] = pat;
            check_ports();
            bus_read(reg_addr(g, 0), v); chk("R3 dir read", v, pat);

            pat = 32'h1234_5678 + 32'(g);
            bus_write(reg_addr(g, 1), pat); m_out[g] = pat;
            chk("R6 direct", pad_out[g*W +: W], pat);
            for (int k = 1; k <= 3; k++) begin
                bus_read(reg_addr(g, k), v); chk("R6 latch read", v, m_out[g]);
            end

            bus_write(reg_addr(g, 2), 32'h8000_00F1); m_out[g] = m_out[g] | 32'h8000_00F1;
            chk("R4 set", pad_out[g*W +: W], m_out[g]);
            bus_write(reg_addr(g, 2), '0);
            chk("R4 set zero", pad_out[g*W +: W], m_out[g]);

            pat = 32'h0000_0071 ^ (32'h0101_0000 << g);
            bus_write(reg_addr(g, 3), pat); m_out[g] = m_out[g] & ~pat;
            chk("R5 clear", pad_out[g*W +: W], m_out[g]);
            bus_write(reg_addr(g, 3), '0);
            chk("R5 clear zero", pad_out[g*W +: W], m_out[g]);

            bus_write(reg_addr(g, 5), 32'hFF00_0000 >> g); m_rise[g] = 32'hFF00_0000 >> g;
            bus_write(reg_addr(g, 5), 32'h0000_00F0); m_rise[g] = m_rise[g] | 32'h0000_00F0;
            bus_write(reg_addr(g, 6), 32'h1000_0030); m_rise[g] = m_rise[g] & ~32'h1000_0030;
            bus_write(reg_addr(g, 7), 32'h00FF_FF00); m_fall[g] = 32'h00FF_FF00;
            bus_write(reg_addr(g, 8), 32'h0000_0F00 << g); m_fall[g] = m_fall[g] & ~(32'h0000_0F00 << g);
            check_ports();
            for (int k = 5; k <= 8; k++) begin
                bus_read(reg_addr(g, k), v); chk("R8 enable read", v, exp_read(reg_addr(g, k)));
            end

            bus_write(reg_addr(g, 4), '1);
            bus_read(reg_addr(g, 4), v); chk("R7 input read", v, m_pad[g]);
            check_ports();

            bus_read(reg_addr(g, 9), v); chk("R9 status read", v, m_stat[g]);
            pat = 32'hC001_0003 ^ (32'h0000_1000 << g);
            bus_write(reg_addr(g, 9), pat);
            for (int h = 0; h < NG; h++) begin
                chk("R9 clear pulse", status_clear[h*W +: W], (h == g) ? pat : '0);
            end
            @(negedge clk);
            for (int h = 0; h < NG; h++) begin
                chk("R9 clear ends", status_clear[h*W +: W], '0);
            end
        end

        read_sweep();

        // R10: writes to every unmapped address are ignored
        for (int a = 0; a < 256; a++) begin
            if (!is_mapped(a)) begin
                bus_write(a, '1);
                for (int h = 0; h < NG; h++) begin
                    chk("R10 no clear", status_clear[h*W +: W], '0);
                end
            end
        end
        check_ports();

        // R11: read data follows the address one edge later
        bus_read(reg_addr(0, 0), vprev);
        @(negedge clk);
        bus_addr = 8'(reg_addr(3, 1));
        #2;
        chk("R11 old word before edge", bus_rdata, m_dir[0]);
        @(negedge clk);
        chk("R11 new word after edge", bus_rdata, m_out[3]);

        // R7: synchronizer lag measured at the read port
        vprev = m_pad[2];
        @(negedge clk);
        bus_addr = 8'(reg_addr(2, 4));
        set_pad(2, ~vprev);
        @(negedge clk);
        chk("R7 lag edge1", bus_rdata, vprev);
        @(negedge clk);
        chk("R7 lag edge2", bus_rdata, vprev);
        @(negedge clk);
        chk("R7 lag edge3", bus_rdata, ~vprev);

        // R7: readback of pins driven as outputs
        bus_write(reg_addr(1, 0), '0); m_dir[1] = '0;
        set_pad(1, 32'h5555_AAAA);
        repeat (3) @(negedge clk);
        bus_read(reg_addr(1, 4), v); chk("R7 output pin read", v, 32'h5555_AAAA);

        check_ports();
        read_sweep();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule